// File: doc/BRIEF.md
# Command-Sequenced Front End for a 64-bit Block Cipher

This block sits between a 32-bit data bus and a lightweight block-cipher core that works on 64-bit blocks with an 80-bit key. The bus cannot carry a whole key or block in one transfer. A 4-bit command therefore picks, one transfer at a time, which word is staged into the key or text register, which cipher operation is launched, or which half of the 64-bit result is placed on the data output.

A sequencer samples the command while it is idle. It spends one cycle in a load or read state, or it stays in a run state while the core works. It drives the word select for the input registers and the control code for the result register. It also handles a start/done handshake with the core. The core receives the staged key and text in parallel, together with a mode code. When it finishes, the sequencer captures either the 64-bit result or, for key derivation, a replacement key.

Top module: `ciphio_ctrl`

## Requirements
- R1: After reset the sequencer is idle, `ready` is 1, `core_start` is 0, `data_out` is zero, `in_sel` and `out_ctl` are both 2'b11, and the key and text registers are zero.
- R2: In idle, command 4'b0010 writes `data_in` into key bits 31:0, 4'b0011 writes key bits 63:32, and 4'b0100 writes `data_in[15:0]` into key bits 79:64. The write happens on the edge that samples the command. During that cycle `in_sel` is 2'b00, 2'b01 and 2'b10 respectively.
- R3: In idle, command 4'b0111 writes `data_in` into text bits 31:0 and 4'b1000 writes text bits 63:32. `in_sel` is 2'b00 and 2'b01 respectively.
- R4: Each load or read command takes the sequencer out of idle for exactly one cycle. During that cycle `ready` is 0 and any command is ignored.
- R5: Command 4'b0110 (encrypt), 4'b0001 (decrypt) and 4'b0101 (derive decryption key) each produce a one-cycle `core_start` pulse in the cycle after the command. `core_mode` is 2'b00, 2'b01 and 2'b10 respectively.
- R6: After a start the sequencer stays busy until `core_done`. For encrypt or decrypt, the cycle with `core_done` shows `out_ctl` = 2'b00 and the result register takes `core_result`. `ready` returns the next cycle.
- R7: When key derivation completes, the key register takes `core_key_next` and the result register is left unchanged.
- R8: Commands that arrive while the core is running are ignored.
- R9: Command 4'b1001 places result bits 31:0 on `data_out` in the following cycle with `out_ctl` = 2'b01. Command 4'b1010 places bits 63:32 there with `out_ctl` = 2'b10.
- R10: Whenever no read state is active, `data_out` is zero.
- R11: Command 4'b0000 and codes 4'b1011 to 4'b1111 have no effect: `ready` stays 1 and the key, text and output do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 4 | Command code |
| data_in | input | 32 | Write word for key and text loads |
| data_out | output | 32 | Selected result half, zero otherwise |
| ready | output | 1 | High only while idle |
| in_sel | output | 2 | Input word select (11 = no load) |
| out_ctl | output | 2 | Result register control (00 load, 01 low, 10 high, 11 off) |
| core_start | output | 1 | One-cycle start pulse to the core |
| core_mode | output | 2 | Operation code for the core |
| core_key | output | 80 | Staged key |
| core_text | output | 64 | Staged text block |
| core_done | input | 1 | Core completion pulse |
| core_result | input | 64 | Core output block |
| core_key_next | input | 80 | Derived key from the core |

## Verification
The bench targets the partial third key word. A design that wrote all 32 bits there, or wrote the wrong slice, would corrupt the key that the core sees. It also drives load commands in the cycle just after a load and during a core run, where a design that still listened would overwrite the staged key or text. Key derivation is checked to replace the key and leave the result untouched, because a design that captured `core_result` for every mode would alter the output halves. Unused codes 1011 to 1111 are applied to catch a decoder that aliases them onto real commands.

// File: rtl/ciphio_pkg.sv
package ciphio_pkg;

    localparam int DATA_W = 32;
    localparam int KEY_W  = 80;
    localparam int TEXT_W = 64;
    localparam int CMD_W  = 4;

    typedef enum logic [CMD_W-1:0] {
        OPC_NOP  = 4'h0,
        OPC_DEC  = 4'h1,
        OPC_KEY0 = 4'h2,
        OPC_KEY1 = 4'h3,
        OPC_KEY2 = 4'h4,
        OPC_KDRV = 4'h5,
        OPC_ENC  = 4'h6,
        OPC_TXT0 = 4'h7,
        OPC_TXT1 = 4'h8,
        OPC_RDLO = 4'h9,
        OPC_RDHI = 4'hA
    } opcode_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_KEY0, ST_KEY1, ST_KEY2,
        ST_TXT0, ST_TXT1, ST_RUN, ST_OUT0, ST_OUT1
    } state_e;

    typedef enum logic [1:0] {
        MODE_ENC  = 2'b00,
        MODE_DEC  = 2'b01,
        MODE_KDRV = 2'b10,
        MODE_NONE = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        KIND_NONE, KIND_LOAD, KIND_RUN, KIND_READ
    } kind_e;

    localparam logic [1:0] ISEL_LO  = 2'b00;
    localparam logic [1:0] ISEL_HI  = 2'b01;
    localparam logic [1:0] ISEL_TOP = 2'b10;
    localparam logic [1:0] ISEL_OFF = 2'b11;

    localparam logic [1:0] OCTL_LOAD = 2'b00;
    localparam logic [1:0] OCTL_LO   = 2'b01;
    localparam logic [1:0] OCTL_HI   = 2'b10;
    localparam logic [1:0] OCTL_OFF  = 2'b11;

    typedef struct packed {
        kind_e       kind;
        logic        to_key;
        logic [1:0]  isel;
        state_e      nxt;
        mode_e       mode;
    } op_t;

    function automatic op_t decode_op(input logic [CMD_W-1:0] c);
        op_t o;
        o.kind   = KIND_NONE;
        o.to_key = 1'b0;
        o.isel   = ISEL_OFF;
        o.nxt    = ST_IDLE;
        o.mode   = MODE_NONE;
        case (c)
            OPC_KEY0: begin o.kind = KIND_LOAD; o.to_key = 1'b1; o.isel = ISEL_LO;  o.nxt = ST_KEY0; end
            OPC_KEY1: begin o.kind = KIND_LOAD; o.to_key = 1'b1; o.isel = ISEL_HI;  o.nxt = ST_KEY1; end
            OPC_KEY2: begin o.kind = KIND_LOAD; o.to_key = 1'b1; o.isel = ISEL_TOP; o.nxt = ST_KEY2; end
            OPC_TXT0: begin o.kind = KIND_LOAD; o.isel = ISEL_LO; o.nxt = ST_TXT0; end
            OPC_TXT1: begin o.kind = KIND_LOAD; o.isel = ISEL_HI; o.nxt = ST_TXT1; end
            OPC_ENC:  begin o.kind = KIND_RUN; o.mode = MODE_ENC;  o.nxt = ST_RUN; end
            OPC_DEC:  begin o.kind = KIND_RUN; o.mode = MODE_DEC;  o.nxt = ST_RUN; end
            OPC_KDRV: begin o.kind = KIND_RUN; o.mode = MODE_KDRV; o.nxt = ST_RUN; end
            OPC_RDLO: begin o.kind = KIND_READ; o.nxt = ST_OUT0; end
            OPC_RDHI: begin o.kind = KIND_READ; o.nxt = ST_OUT1; end
            default:  o.kind = KIND_NONE;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/ciphio_seq.sv
module ciphio_seq
    import ciphio_pkg::*;
#(
    parameter int CW = CMD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cmd,
    input  logic          core_done,
    output logic          ready,
    output logic [1:0]    in_sel,
    output logic          ld_key,
    output logic          ld_text,
    output logic [1:0]    out_ctl,
    output logic          key_upd,
    output logic          core_start,
    output logic [1:0]    core_mode
);

    state_e state_q, state_d;
    logic   start_q;
    mode_e  mode_q;
    op_t    op;
    logic   idle;
    logic   capture;

    assign op   = decode_op(cmd);
    assign idle = (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: state_d = op.nxt;
            ST_RUN:  if (capture) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign capture = (state_q == ST_RUN) && core_done && !start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            start_q <= 1'b0;
            mode_q  <= MODE_NONE;
        end else begin
            state_q <= state_d;
            start_q <= idle && (op.kind == KIND_RUN);
            if (idle && (op.kind == KIND_RUN))
                mode_q <= op.mode;
        end
    end

    always_comb begin
        in_sel  = ISEL_OFF;
        ld_key  = 1'b0;
        ld_text = 1'b0;
        if (idle && op.kind == KIND_LOAD) begin
            in_sel  = op.isel;
            ld_key  = op.to_key;
            ld_text = !op.to_key;
        end
    end

    always_comb begin
        out_ctl = OCTL_OFF;
        if (capture && mode_q != MODE_KDRV)
            out_ctl = OCTL_LOAD;
        else if (state_q == ST_OUT0)
            out_ctl = OCTL_LO;
        else if (state_q == ST_OUT1)
            out_ctl = OCTL_HI;
    end

    assign key_upd    = capture && (mode_q == MODE_KDRV);
    assign ready      = idle;
    assign core_start = start_q;
    assign core_mode  = mode_q;

    p_start_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        core_start |=> !core_start);

    p_start_in_run_r5: assert property (@(posedge clk) disable iff (rst)
        core_start |-> (state_q == ST_RUN));

    p_short_visit_r4: assert property (@(posedge clk) disable iff (rst)
        (!idle && state_q != ST_RUN) |=> idle);

    p_run_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && !core_done) |=> (state_q == ST_RUN));

endmodule

// File: rtl/ciphio_opregs.sv
module ciphio_opregs
    import ciphio_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int KW = KEY_W,
    parameter int TW = TEXT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] data_in,
    input  logic [1:0]    in_sel,
    input  logic          ld_key,
    input  logic          ld_text,
    input  logic          key_upd,
    input  logic [KW-1:0] key_next,
    output logic [KW-1:0] key_q,
    output logic [TW-1:0] text_q
);

    localparam int KEY_WORDS  = (KW + DW - 1) / DW;
    localparam int TEXT_WORDS = (TW + DW - 1) / DW;

    logic [KW-1:0] key_d;
    logic [TW-1:0] text_d;

    always_comb begin
        key_d = key_q;
        if (key_upd) begin
            key_d = key_next;
        end else if (ld_key) begin
            for (int b = 0; b < KW; b++)
                if ((b / DW) == int'(in_sel) && (b / DW) < KEY_WORDS)
                    key_d[b] = data_in[b % DW];
        end
    end

    always_comb begin
        text_d = text_q;
        if (ld_text) begin
            for (int b = 0; b < TW; b++)
                if ((b / DW) == int'(in_sel) && (b / DW) < TEXT_WORDS)
                    text_d[b] = data_in[b % DW];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q  <= '0;
            text_q <= '0;
        end else begin
            key_q  <= key_d;
            text_q <= text_d;
        end
    end

    p_key_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!ld_key && !key_upd) |=> $stable(key_q));

    p_text_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!ld_text) |=> $stable(text_q));

endmodule

// File: rtl/ciphio_resreg.sv
module ciphio_resreg
    import ciphio_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int TW = TEXT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    out_ctl,
    input  logic [TW-1:0] result_in,
    output logic [DW-1:0] data_out
);

    logic [TW-1:0] res_q;

    always_ff @(posedge clk) begin
        if (rst)
            res_q <= '0;
        else if (out_ctl == OCTL_LOAD)
            res_q <= result_in;
    end

    always_comb begin
        case (out_ctl)
            OCTL_LO: data_out = res_q[DW-1:0];
            OCTL_HI: data_out = res_q[2*DW-1:DW];
            default: data_out = '0;
        endcase
    end

    p_res_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (out_ctl != OCTL_LOAD) |=> $stable(res_q));

    p_out_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (out_ctl == OCTL_OFF || out_ctl == OCTL_LOAD) |-> (data_out == '0));

endmodule

// File: rtl/ciphio_ctrl.sv
module ciphio_ctrl
    import ciphio_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int KW = KEY_W,
    parameter int TW = TEXT_W,
    parameter int CW = CMD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cmd,
    input  logic [DW-1:0] data_in,
    output logic [DW-1:0] data_out,
    output logic          ready,
    output logic [1:0]    in_sel,
    output logic [1:0]    out_ctl,
    output logic          core_start,
    output logic [1:0]    core_mode,
    output logic [KW-1:0] core_key,
    output logic [TW-1:0] core_text,
    input  logic          core_done,
    input  logic [TW-1:0] core_result,
    input  logic [KW-1:0] core_key_next
);

    logic ld_key, ld_text, key_upd;

    ciphio_seq #(.CW(CW)) u_seq (
        .clk(clk), .rst(rst), .cmd(cmd), .core_done(core_done),
        .ready(ready), .in_sel(in_sel), .ld_key(ld_key), .ld_text(ld_text),
        .out_ctl(out_ctl), .key_upd(key_upd),
        .core_start(core_start), .core_mode(core_mode)
    );

    ciphio_opregs #(.DW(DW), .KW(KW), .TW(TW)) u_opregs (
        .clk(clk), .rst(rst), .data_in(data_in), .in_sel(in_sel),
        .ld_key(ld_key), .ld_text(ld_text), .key_upd(key_upd),
        .key_next(core_key_next), .key_q(core_key), .text_q(core_text)
    );

    ciphio_resreg #(.DW(DW), .TW(TW)) u_resreg (
        .clk(clk), .rst(rst), .out_ctl(out_ctl),
        .result_in(core_result), .data_out(data_out)
    );

    p_busy_key_r8: assert property (@(posedge clk) disable iff (rst)
        (!ready && !core_done) |=> $stable(core_key));

endmodule

// File: tb/test_ciphio_ctrl.sv
module test_ciphio_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  cmd;
    logic [31:0] data_in;
    logic [31:0] data_out;
    logic        ready;
    logic [1:0]  in_sel, out_ctl, core_mode;
    logic        core_start, core_done;
    logic [79:0] core_key, core_key_next;
    logic [63:0] core_text, core_result;

    int vectors = 0;
    int fails = 0;
    bit finished = 0;

    typedef struct { logic hi; logic [31:0] word; } rd_t;
    rd_t exp_q[$];

    logic [79:0] mk;
    logic [63:0] mt, mres;

    always #(CLK_PERIOD/2) clk = ~clk;

    ciphio_ctrl i_ciphio_ctrl (
        .clk(clk), .rst(rst), .cmd(cmd), .data_in(data_in), .data_out(data_out),
        .ready(ready), .in_sel(in_sel), .out_ctl(out_ctl),
        .core_start(core_start), .core_mode(core_mode),
        .core_key(core_key), .core_text(core_text),
        .core_done(core_done), .core_result(core_result),
        .core_key_next(core_key_next)
    );

    // Core stub: fixed latency, simple reversible-looking mixing
    int cnt;
    always_ff @(posedge clk) begin
        if (rst) cnt <= 0;
        else if (core_start) cnt <= LAT;
        else if (cnt != 0) cnt <= cnt - 1;
    end
    assign core_done = (cnt == 1);

    function automatic logic [63:0] f_res(logic [1:0] m, logic [79:0] k, logic [63:0] t);
        if (m == 2'b00) return {t[31:0], t[63:32]} ^ k[63:0];
        return t ^ k[79:16];
    endfunction
    function automatic logic [79:0] f_key(logic [79:0] k);
        return {k[18:0], k[79:19]};
    endfunction
    assign core_result   = f_res(core_mode, core_key, core_text);
    assign core_key_next = f_key(core_key);

    task automatic check(bit ok, string req, logic [79:0] act, logic [79:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: pops expected read words
    always @(negedge clk) begin
        if (!rst && (out_ctl == 2'b01 || out_ctl == 2'b10)) begin
            if (exp_q.size() == 0) begin
                check(0, "R9 unexpected read", {78'd0, out_ctl}, 80'd3);
            end else begin
                rd_t e;
                e = exp_q.pop_front();
                check(out_ctl == (e.hi ? 2'b10 : 2'b01), "R9 out_ctl", {78'd0, out_ctl}, {78'd0, e.hi ? 2'b10 : 2'b01});
                check(data_out == e.word, "R9 data_out", {48'd0, data_out}, {48'd0, e.word});
            end
        end
    end

    task automatic load(logic [3:0] c, logic [31:0] d, logic [1:0] isel_exp, string req, bit stray);
        @(negedge clk);
        cmd = c; data_in = d;
        #1 check(in_sel == isel_exp, req, {78'd0, in_sel}, {78'd0, isel_exp});
        @(negedge clk);
        check(ready == 1'b0, "R4 ready low in load state", {79'd0, ready}, 80'd0);
        cmd = stray ? 4'h7 : 4'h0;
        data_in = 32'hBAD0_BAD0;
        case (c)
            4'h2: mk[31:0]  = d;
            4'h3: mk[63:32] = d;
            4'h4: mk[79:64] = d[15:0];
            4'h7: mt[31:0]  = d;
            4'h8: mt[63:32] = d;
            default: ;
        endcase
        @(negedge clk);
        cmd = 4'h0;
        check(ready == 1'b1, "R4 back to idle", {79'd0, ready}, 80'd1);
        check(core_key == mk, req, core_key, mk);
        check(core_text == mt, req, {16'd0, core_text}, {16'd0, mt});
    endtask

    task automatic run(logic [3:0] c, logic [1:0] m, bit stray);
        @(negedge clk);
        cmd = c;
        @(negedge clk);
        cmd = stray ? 4'h2 : 4'h0;
        data_in = 32'hDEAD_BEEF;
        check(core_start == 1'b1, "R5 start pulse", {79'd0, core_start}, 80'd1);
        check(core_mode == m, "R5 mode", {78'd0, core_mode}, {78'd0, m});
        @(negedge clk);
        cmd = 4'h0;
        check(core_start == 1'b0, "R5 start one cycle", {79'd0, core_start}, 80'd0);
        for (int i = 0; i < 50 && !core_done; i++) begin
            check(ready == 1'b0, "R6 busy until done", {79'd0, ready}, 80'd0);
            @(negedge clk);
        end
        if (m == 2'b10) begin
            check(out_ctl == 2'b11, "R7 no result load", {78'd0, out_ctl}, 80'd3);
            mk = f_key(mk);
        end else begin
            check(out_ctl == 2'b00, "R6 capture control", {78'd0, out_ctl}, 80'd0);
            mres = f_res(m, mk, mt);
        end
        @(negedge clk);
        check(ready == 1'b1, "R6 ready after done", {79'd0, ready}, 80'd1);
        check(core_key == mk, stray ? "R8 key untouched during run" : "R7 key after run", core_key, mk);
    endtask

    task automatic rd(bit hi);
        rd_t e;
        e.hi = hi;
        e.word = hi ? mres[63:32] : mres[31:0];
        exp_q.push_back(e);
        @(negedge clk);
        cmd = hi ? 4'hA : 4'h9;
        @(negedge clk);
        cmd = 4'h0;
        @(negedge clk);
        check(data_out == 32'd0, "R10 output zero after read", {48'd0, data_out}, 80'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cmd = 4'h0; data_in = 32'd0;
        mk = '0; mt = '0; mres = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(ready == 1'b1, "R1 ready", {79'd0, ready}, 80'd1);
        check(core_start == 1'b0, "R1 start", {79'd0, core_start}, 80'd0);
        check(data_out == 32'd0, "R1 data_out", {48'd0, data_out}, 80'd0);
        check(in_sel == 2'b11 && out_ctl == 2'b11, "R1 controls", {76'd0, in_sel, out_ctl}, 80'hF);
        check(core_key == 80'd0 && core_text == 64'd0, "R1 regs", core_key, 80'd0);

        // R2 key loads, third part only 16 bits
        load(4'h2, 32'h0123_4567, 2'b00, "R2 key word0", 0);
        load(4'h3, 32'h89AB_CDEF, 2'b01, "R2 key word1", 0);
        load(4'h4, 32'hFFFF_A5C3, 2'b10, "R2 key top16", 0);
        // R3 text loads, R4 stray command in load state
        load(4'h7, 32'h1122_3344, 2'b00, "R3 text low", 1);
        load(4'h8, 32'h5566_7788, 2'b01, "R3 text high", 1);

        // R11 unused codes and nop
        for (int c = 11; c < 16; c++) begin
            @(negedge clk);
            cmd = 4'(c); data_in = 32'hFFFF_FFFF;
            @(negedge clk);
            cmd = 4'h0;
            check(ready == 1'b1, "R11 ready stays", {79'd0, ready}, 80'd1);
            check(data_out == 32'd0, "R11 no output", {48'd0, data_out}, 80'd0);
            check(core_key == mk && core_text == mt, "R11 regs unchanged", core_key, mk);
        end

        // R5/R6 encrypt, R8 stray load during run
        run(4'h6, 2'b00, 1);
        rd(0);
        rd(1);
        // decrypt
        run(4'h1, 2'b01, 0);
        rd(1);
        rd(0);
        // R7 key derivation keeps result
        run(4'h5, 2'b10, 0);
        rd(0);
        rd(1);
        // encrypt with derived key and new text
        load(4'h7, 32'hCAFE_F00D, 2'b00, "R3 text low again", 0);
        run(4'h6, 2'b00, 0);
        rd(0);
        rd(1);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9 all reads seen", {48'd0, 32'(exp_q.size())}, 80'd0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule